// File: doc/BRIEF.md
# Paging receiver lock-mode controller

This block is the mode sequencer of a paging decoder. It follows the pager through three operating modes: idle, preamble search and lock. It drives the receiver power-enable so that, once locked, the radio is powered only for the batch sync codeword and for the two codewords of the frame assigned to this pager. Demodulation, error correction, sync-word correlation and address comparison sit outside the block. Their results arrive as single-cycle flags that come with `cw_tick`, a strobe marking the end of each received codeword.

Once an address matches in the assigned frame, the controller enters message reception. It keeps the receiver on across frame and batch boundaries until the message ends. The end-of-message rules depend on a mode input. In normal mode, an address or idle codeword ends the message. In break-only mode, only a host break request ends it, and foreign address codewords are kept as message content. An end-of-message flag ends reception in both modes. Lost sync is counted at each batch's sync slot. Two consecutive misses drop the pager back to idle, or to preamble search when a preamble pattern is visible at that moment. No data stream passes through the block, so it has no valid/ready handshake. All of its pins are plain control and status signals.

Top module: `plk_lock_ctrl`

## Requirements
- R1: After reset, `mode` is 0 (idle), `rx_pwr` is 0 and `msg_active` is 0. The mode encoding is 0 = idle, 1 = preamble, 2 = lock; lock covers both waiting and message reception.
- R2: In idle, `cw_tick` with `pre_det` moves to preamble, which holds `rx_pwr` high. A `sync_det` seen in idle is ignored.
- R3: In preamble, `cw_tick` with `sync_det` moves to lock and restarts the batch position, so the next codeword is the first codeword of frame 0. `rx_pwr` then goes low, except when `cfg_frame` is 0, in which case it stays high.
- R4: A locked batch is one sync codeword followed by 8 frames of 2 codewords, each ended by one `cw_tick`. While locked and not receiving, `rx_pwr` is high exactly during the sync codeword and both codewords of frame `cfg_frame`.
- R5: `addr_match` on a `cw_tick` ending either codeword of the assigned frame starts message reception. From the next cycle, `msg_active` and `rx_pwr` are both 1. An `addr_match` outside the assigned frame is ignored.
- R6: While locked and not receiving, a sync-slot `cw_tick` without `sync_det` counts a miss, and one with `sync_det` clears the count. The second consecutive miss moves to idle with `rx_pwr` low.
- R7: If `pre_det` accompanies that second miss, the move goes to preamble instead of idle.
- R8: During message reception, missed syncs neither count nor leave lock. Reception continues across batch boundaries.
- R9: In normal mode (`cfg_break_only` = 0), `addr_cw` or `idle_cw` on a `cw_tick` of a non-sync codeword ends reception. `brk_req` is ignored.
- R10: In break-only mode, `addr_cw` and `idle_cw` do not end reception. `brk_req` on any cycle ends it on the next cycle, even when it lands on a sync-slot tick.
- R11: `eom_det` on a non-sync codeword tick ends reception in both modes. After any end, `rx_pwr` returns to the R4 schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_frame | input | 3 | Assigned frame number, 0 to 7 |
| cfg_break_only | input | 1 | 1 = only a host break ends a message |
| cw_tick | input | 1 | End-of-codeword strobe; the flags below are valid with it |
| sync_det | input | 1 | Sync codeword recognised |
| pre_det | input | 1 | Preamble pattern recognised |
| addr_match | input | 1 | Own address recognised |
| addr_cw | input | 1 | Codeword is an address codeword |
| idle_cw | input | 1 | Codeword is an idle codeword |
| eom_det | input | 1 | End-of-message indication |
| brk_req | input | 1 | Host break request, any cycle |
| rx_pwr | output | 1 | Receiver power enable |
| msg_active | output | 1 | Message reception in progress |
| mode | output | 2 | 0 idle, 1 preamble, 2 lock |

## Verification
The interesting coincidence is a host break that arrives on the same cycle as a sync-slot tick whose sync check fails. Two things happen at once: reception ends, and the sync miss is evaluated. The bench provokes this in break-only mode by holding `brk_req` high during the missed sync tick. It then checks that this miss is not counted. A following single miss must leave the pager locked, and only the miss after that sends it to idle. The behavioural reference model sees the same inputs and is compared against `mode`, `msg_active` and `rx_pwr` on every clock.

// File: rtl/plk_pkg.sv
package plk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_WAIT = 2'd2,
    ST_MSG  = 2'd3
  } plk_state_e;

  localparam logic [1:0] MODE_IDLE = 2'd0;
  localparam logic [1:0] MODE_PRE  = 2'd1;
  localparam logic [1:0] MODE_LOCK = 2'd2;
endpackage

// File: rtl/plk_slot_ctr.sv
// Position of the codeword in progress within a batch: 0 is the sync slot,
// 1..LAST are the frame codewords in order.
module plk_slot_ctr #(
  parameter int FRAMES = 8,
  parameter int CPF    = 2,
  parameter int SW     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          restart,
  input  logic          clear,
  output logic [SW-1:0] slot_q
);
  localparam int LAST = FRAMES * CPF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (clear) begin
      slot_q <= '0;
    end else if (restart) begin
      slot_q <= SW'(1);
    end else if (adv) begin
      if (slot_q == SW'(LAST)) slot_q <= '0;
      else                     slot_q <= slot_q + SW'(1);
    end
  end
endmodule

// File: rtl/plk_sync_watch.sv
// Counts consecutive missed sync checks; flags loss on the limit-th miss.
module plk_sync_watch #(
  parameter int MISS_LIMIT = 2,
  parameter int MW         = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic check,
  input  logic hit,
  input  logic count_en,
  input  logic clear,
  output logic lost
);
  logic [MW-1:0] miss_q;
  logic          miss_now;

  assign miss_now = check && !hit && count_en;
  assign lost     = miss_now && (miss_q == MW'(MISS_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      miss_q <= '0;
    end else if (clear || (check && hit) || lost) begin
      miss_q <= '0;
    end else if (miss_now) begin
      miss_q <= miss_q + MW'(1);
    end
  end
endmodule

// File: rtl/plk_wake.sv
// Receiver power decision and assigned-frame decode.
module plk_wake
  import plk_pkg::*;
#(
  parameter int CPF = 2,
  parameter int SW  = 5,
  parameter int FW  = 3
) (
  input  plk_state_e    state,
  input  logic [SW-1:0] slot,
  input  logic [FW-1:0] frame,
  output logic          in_frame,
  output logic          rx_pwr
);
  logic [CPF-1:0] hit;

  for (genvar k = 0; k < CPF; k++) begin : g_cw
    assign hit[k] = ({1'b0, slot} ==
                     ((SW+1)'(frame) * (SW+1)'(CPF)) + (SW+1)'(k + 1));
  end

  assign in_frame = |hit;

  always_comb begin
    unique case (state)
      ST_IDLE: rx_pwr = 1'b0;
      ST_PRE:  rx_pwr = 1'b1;
      ST_MSG:  rx_pwr = 1'b1;
      default: rx_pwr = (slot == '0) || in_frame;
    endcase
  end
endmodule

// File: rtl/plk_msg_end.sv
// Decides when an active message reception terminates.
module plk_msg_end (
  input  logic in_msg,
  input  logic tick,
  input  logic data_slot,
  input  logic break_only,
  input  logic addr_cw,
  input  logic idle_cw,
  input  logic eom,
  input  logic brk,
  output logic stop
);
  logic cw_end;
  logic host_end;

  assign cw_end   = tick && data_slot &&
                    (eom || (!break_only && (addr_cw || idle_cw)));
  assign host_end = break_only && brk;
  assign stop     = in_msg && (cw_end || host_end);
endmodule

// File: rtl/plk_lock_ctrl.sv
module plk_lock_ctrl
  import plk_pkg::*;
#(
  parameter int FRAMES     = 8,
  parameter int CPF        = 2,
  parameter int MISS_LIMIT = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(FRAMES)-1:0]   cfg_frame,
  input  logic                        cfg_break_only,
  input  logic                        cw_tick,
  input  logic                        sync_det,
  input  logic                        pre_det,
  input  logic                        addr_match,
  input  logic                        addr_cw,
  input  logic                        idle_cw,
  input  logic                        eom_det,
  input  logic                        brk_req,
  output logic                        rx_pwr,
  output logic                        msg_active,
  output logic [1:0]                  mode
);
  localparam int FW    = $clog2(FRAMES);
  localparam int SLOTS = 1 + FRAMES * CPF;
  localparam int SW    = $clog2(SLOTS);
  localparam int MW    = $clog2(MISS_LIMIT + 1);

  plk_state_e    state_q, state_d;
  logic [SW-1:0] slot_q;
  logic          locked, sync_slot, in_frame, lost, stop;
  logic          restart, slot_clear, slot_adv;

  assign locked    = (state_q == ST_WAIT) || (state_q == ST_MSG);
  assign sync_slot = (slot_q == '0);
  assign restart   = (state_q == ST_PRE) && cw_tick && sync_det;
  assign slot_clear = lost;
  assign slot_adv  = cw_tick && locked;

  plk_slot_ctr #(.FRAMES(FRAMES), .CPF(CPF), .SW(SW)) u_slot (
    .clk(clk), .rst_n(rst_n), .adv(slot_adv), .restart(restart),
    .clear(slot_clear), .slot_q(slot_q)
  );

  plk_sync_watch #(.MISS_LIMIT(MISS_LIMIT), .MW(MW)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .check(cw_tick && locked && sync_slot),
    .hit(sync_det),
    .count_en(state_q == ST_WAIT),
    .clear(restart),
    .lost(lost)
  );

  plk_wake #(.CPF(CPF), .SW(SW), .FW(FW)) u_wake (
    .state(state_q), .slot(slot_q), .frame(cfg_frame),
    .in_frame(in_frame), .rx_pwr(rx_pwr)
  );

  plk_msg_end u_end (
    .in_msg(state_q == ST_MSG), .tick(cw_tick), .data_slot(!sync_slot),
    .break_only(cfg_break_only), .addr_cw(addr_cw), .idle_cw(idle_cw),
    .eom(eom_det), .brk(brk_req), .stop(stop)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (cw_tick && pre_det) state_d = ST_PRE;
      ST_PRE:  if (restart) state_d = ST_WAIT;
      ST_WAIT: begin
        if (lost)                                  state_d = pre_det ? ST_PRE : ST_IDLE;
        else if (cw_tick && in_frame && addr_match) state_d = ST_MSG;
      end
      ST_MSG:  if (stop) state_d = ST_WAIT;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign msg_active = (state_q == ST_MSG);
  always_comb begin
    unique case (state_q)
      ST_IDLE: mode = MODE_IDLE;
      ST_PRE:  mode = MODE_PRE;
      default: mode = MODE_LOCK;
    endcase
  end
endmodule

// File: rtl/plk_lock_ctrl_chk.sv
module plk_lock_ctrl_chk #(
  parameter int SW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_break_only,
  input logic          cw_tick,
  input logic          sync_det,
  input logic          eom_det,
  input logic          brk_req,
  input logic          rx_pwr,
  input logic          msg_active,
  input logic [1:0]    mode,
  input logic [SW-1:0] slot
);
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mode == 2'd0 && !rx_pwr && !msg_active));

  p_pre_powered_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> rx_pwr);

  p_sync_locks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && cw_tick && sync_det) |=> (mode == 2'd2 && !msg_active));

  p_sync_slot_awake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && slot == '0) |-> rx_pwr);

  p_msg_powered_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_active |-> rx_pwr);

  p_idle_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> (!rx_pwr && !msg_active));

  p_msg_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_active |-> (mode == 2'd2));

  p_brk_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_break_only && msg_active && brk_req && !cw_tick) |=> msg_active);

  p_brk_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_break_only && msg_active && brk_req) |=> !msg_active);

  p_eom_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_active && cw_tick && eom_det && slot != '0) |=> !msg_active);
endmodule

bind plk_lock_ctrl plk_lock_ctrl_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_break_only(cfg_break_only),
  .cw_tick(cw_tick), .sync_det(sync_det), .eom_det(eom_det),
  .brk_req(brk_req), .rx_pwr(rx_pwr), .msg_active(msg_active),
  .mode(mode), .slot(slot_q)
);

// File: tb/tb_plk_lock_ctrl.sv
module tb_plk_lock_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_frame = 3'd3;
  logic       cfg_break_only = 1'b0;
  logic       cw_tick = 0, sync_det = 0, pre_det = 0, addr_match = 0;
  logic       addr_cw = 0, idle_cw = 0, eom_det = 0, brk_req = 0;
  logic       rx_pwr, msg_active;
  logic [1:0] mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  plk_lock_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_frame(cfg_frame),
    .cfg_break_only(cfg_break_only), .cw_tick(cw_tick),
    .sync_det(sync_det), .pre_det(pre_det), .addr_match(addr_match),
    .addr_cw(addr_cw), .idle_cw(idle_cw), .eom_det(eom_det),
    .brk_req(brk_req), .rx_pwr(rx_pwr), .msg_active(msg_active),
    .mode(mode)
  );

  // Reference model: 0 idle, 1 preamble, 2 lock waiting, 3 lock receiving
  int m_st = 0, m_slot = 0, m_miss = 0;

  function automatic bit m_assigned(int s);
    return (s >= 2 * int'(cfg_frame) + 1) && (s <= 2 * int'(cfg_frame) + 2);
  endfunction

  function automatic bit m_pwr();
    case (m_st)
      0: return 1'b0;
      1, 3: return 1'b1;
      default: return (m_slot == 0) || m_assigned(m_slot);
    endcase
  endfunction

  always @(posedge clk) begin
    int nst, nslot, nmiss;
    bit lost, stop;
    if (!rst_n) begin
      m_st = 0; m_slot = 0; m_miss = 0;
    end else begin
      nst = m_st; nslot = m_slot; nmiss = m_miss; lost = 0; stop = 0;
      if (m_st == 0) begin
        if (cw_tick && pre_det) nst = 1;
      end else if (m_st == 1) begin
        if (cw_tick && sync_det) begin nst = 2; nslot = 1; nmiss = 0; end
      end else begin
        if (m_st == 3)
          stop = (cfg_break_only && brk_req) ||
                 (cw_tick && m_slot != 0 &&
                  (eom_det || (!cfg_break_only && (addr_cw || idle_cw))));
        if (cw_tick && m_slot == 0) begin
          if (sync_det) nmiss = 0;
          else if (m_st == 2) begin
            if (m_miss + 1 >= 2) begin lost = 1; nmiss = 0; end
            else nmiss = m_miss + 1;
          end
        end
        if (lost) begin
          nst = pre_det ? 1 : 0; nslot = 0;
        end else begin
          if (m_st == 2 && cw_tick && addr_match && m_assigned(m_slot)) nst = 3;
          if (stop) nst = 2;
          if (cw_tick) nslot = (m_slot == 16) ? 0 : m_slot + 1;
        end
      end
      m_st = nst; m_slot = nslot; m_miss = nmiss;
    end
  end

  // Every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int em;
      em = (m_st >= 2) ? 2 : m_st;
      checks++;
      if (mode != 2'(em) || msg_active != (m_st == 3) || rx_pwr != m_pwr()) begin
        errors++;
        $display("FAIL %s model: mode=%0d msg=%0b pwr=%0b expected mode=%0d msg=%0b pwr=%0b",
                 cur_req, mode, msg_active, rx_pwr, em, (m_st == 3), m_pwr());
      end
    end
  end

  task automatic chk(input string req, input logic [1:0] em, input bit emsg, input bit epwr);
    checks++;
    if (mode !== em || msg_active !== emsg || rx_pwr !== epwr) begin
      errors++;
      $display("FAIL %s: mode=%0d msg=%0b pwr=%0b expected mode=%0d msg=%0b pwr=%0b",
               req, mode, msg_active, rx_pwr, em, emsg, epwr);
    end
  endtask

  task automatic cw(input bit s, p, am, ac, ic, eo, bk);
    cw_tick = 1; sync_det = s; pre_det = p; addr_match = am;
    addr_cw = ac; idle_cw = ic; eom_det = eo; brk_req = bk;
    @(negedge clk);
    cw_tick = 0; sync_det = 0; pre_det = 0; addr_match = 0;
    addr_cw = 0; idle_cw = 0; eom_det = 0; brk_req = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic brk_pulse();
    brk_req = 1;
    @(negedge clk);
    brk_req = 0;
    @(negedge clk);
  endtask

  task automatic advance_to(input int t, input bit s_ok);
    for (int n = 0; n < 20 && m_slot != t; n++)
      cw((m_slot == 0) ? s_ok : 1'b0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", 2'd0, 0, 0);

    cur_req = "R2";
    cw(1, 0, 0, 0, 0, 0, 0);               // sync ignored in idle
    chk("R2", 2'd0, 0, 0);
    cw(0, 1, 0, 0, 0, 0, 0);
    chk("R2", 2'd1, 0, 1);

    cur_req = "R3";
    cw(1, 0, 0, 0, 0, 0, 0);
    chk("R3", 2'd2, 0, 0);

    cur_req = "R4";
    advance_to(7, 1);
    chk("R4", 2'd2, 0, 1);
    cw(0, 0, 0, 0, 0, 0, 0);
    chk("R4", 2'd2, 0, 1);
    cw(0, 0, 0, 0, 0, 0, 0);
    chk("R4", 2'd2, 0, 0);
    advance_to(0, 1);
    chk("R4", 2'd2, 0, 1);

    cur_req = "R5";
    cw(1, 0, 0, 0, 0, 0, 0);
    advance_to(3, 1);
    cw(0, 0, 1, 0, 0, 0, 0);               // outside assigned frame
    chk("R5", 2'd2, 0, 0);
    advance_to(8, 1);
    cw(0, 0, 1, 0, 0, 0, 0);               // second codeword of frame 3
    chk("R5", 2'd2, 1, 1);

    cur_req = "R8";
    advance_to(0, 1);
    cw(0, 0, 0, 0, 0, 0, 0);
    advance_to(0, 0);
    cw(0, 0, 0, 0, 0, 0, 0);
    chk("R8", 2'd2, 1, 1);

    cur_req = "R9";
    brk_pulse();
    chk("R9", 2'd2, 1, 1);
    cw(0, 0, 0, 0, 1, 0, 0);               // idle codeword at slot 1
    chk("R9", 2'd2, 0, 0);
    advance_to(7, 1);
    cw(0, 0, 1, 0, 0, 0, 0);
    cw(0, 0, 0, 1, 0, 0, 0);               // address codeword
    chk("R9", 2'd2, 0, 0);

    cur_req = "R10";
    cfg_break_only = 1;
    advance_to(7, 1);
    cw(0, 0, 1, 0, 0, 0, 0);
    cw(0, 0, 0, 1, 0, 0, 0);
    chk("R10", 2'd2, 1, 1);
    cw(0, 0, 0, 0, 1, 0, 0);
    chk("R10", 2'd2, 1, 1);
    brk_pulse();
    chk("R10", 2'd2, 0, 0);

    cur_req = "R11";
    advance_to(7, 1);
    cw(0, 0, 1, 0, 0, 0, 0);
    cw(0, 0, 0, 0, 0, 1, 0);
    chk("R11", 2'd2, 0, 0);
    cfg_break_only = 0;
    advance_to(7, 1);
    cw(0, 0, 1, 0, 0, 0, 0);
    cw(0, 0, 0, 0, 0, 1, 0);
    chk("R11", 2'd2, 0, 0);
    advance_to(0, 1);
    chk("R11", 2'd2, 0, 1);

    // Break on the same tick as a missed sync: that miss is not counted
    cur_req = "R10";
    cfg_break_only = 1;
    cw(1, 0, 0, 0, 0, 0, 0);
    advance_to(7, 1);
    cw(0, 0, 1, 0, 0, 0, 0);
    advance_to(0, 1);
    cw(0, 0, 0, 0, 0, 0, 1);
    chk("R10", 2'd2, 0, 0);
    cur_req = "R6";
    cfg_break_only = 0;
    advance_to(0, 1);
    cw(0, 0, 0, 0, 0, 0, 0);
    chk("R6", 2'd2, 0, 0);
    advance_to(0, 1);
    cw(0, 0, 0, 0, 0, 0, 0);
    chk("R6", 2'd0, 0, 0);

    cur_req = "R7";
    cw(0, 1, 0, 0, 0, 0, 0);
    cw(1, 0, 0, 0, 0, 0, 0);
    advance_to(0, 1);
    cw(0, 0, 0, 0, 0, 0, 0);
    advance_to(0, 1);
    cw(0, 1, 0, 0, 0, 0, 0);
    chk("R7", 2'd1, 0, 1);

    cur_req = "R6";
    cw(1, 0, 0, 0, 0, 0, 0);
    advance_to(0, 1);
    cw(0, 0, 0, 0, 0, 0, 0);
    advance_to(0, 1);
    cw(1, 0, 0, 0, 0, 0, 0);               // hit clears the count
    advance_to(0, 1);
    cw(0, 0, 0, 0, 0, 0, 0);
    chk("R6", 2'd2, 0, 0);
    advance_to(0, 1);
    cw(0, 0, 0, 0, 0, 0, 0);
    chk("R6", 2'd0, 0, 0);

    cur_req = "R3";
    cfg_frame = 3'd0;
    cw(0, 1, 0, 0, 0, 0, 0);
    cw(1, 0, 0, 0, 0, 0, 0);
    chk("R3", 2'd2, 0, 1);
    cur_req = "R4";
    cw(0, 0, 0, 0, 0, 0, 0);
    chk("R4", 2'd2, 0, 1);
    cw(0, 0, 0, 0, 0, 0, 0);
    chk("R4", 2'd2, 0, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule